// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves incoming packets from a byte-stream port into memory buffers that software lends to it through a circular list of descriptors. Software places the descriptors in memory that both the processor and the engine reach. It sets the ownership bit of each descriptor to "device", then programs the ring start address and the number of entries and turns the engine on. When a packet starts, the engine reads the descriptor at its current ring position over a simple memory-master port. If the engine owns that descriptor, it stores the packet bytes in order into the buffer. It then writes the stored length back, hands the descriptor to the host, and signals completion.

Software takes the packet, sets the ownership bit again, and the ring goes on without any restart. If the next descriptor still belongs to the host, the engine takes the packet off the port and discards it, and it records a sticky overrun status. The ring position then stays where it is, so the packet that follows retries the same descriptor.

Top module: `rxr_dma_ring`

## Requirements
- R1: After reset, irq is 0, sts is 0, rx_ready is 0 and mem_req is 0.
- R2: While cfg_en is 0, rx_ready stays 0 and no memory access is made. Turning the engine off returns the ring position to descriptor 0.
- R3: Descriptor i lies at byte address cfg_base + 8*i. The word at offset 0 holds the buffer byte address. The word at offset 4 is the control word: bit 31 is ownership (1 = device) and bits [13:0] are the buffer size in bytes. The control word is read first, when a packet starts.
- R4: Packet bytes are stored in arrival order at buffer address + offset. Each byte is a single write with mem_we = 1, where mem_be has only the lane mem_addr[1:0] set and that byte is placed on that lane of mem_wdata.
- R5: At the end of a packet the control word is written back. Bit 31 is cleared to host, bit 30 is the error flag, bits [29:16] hold the number of bytes stored and bits [13:0] hold the buffer size unchanged.
- R6: A packet longer than its buffer stores only size bytes, sets bit 30 in the written-back word, and writes nothing past the end of the buffer.
- R7: Packets use descriptors in strict ring order. After descriptor cfg_count-1 the position wraps to 0.
- R8: When the control word read at packet start shows host ownership, the packet is accepted and dropped. No memory write is made, sts[1] is set and stays set, and the ring position does not move.
- R9: sts[0] rises on the clock edge that follows the accepted write-back of the control word. irq is the OR of sts[1:0]. Each sts bit stays 1 until a 1 is applied on the matching sts_clr bit.
- R10: A descriptor that software hands back to the device is used again on the next pass around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Engine enable |
| cfg_base | input | AW | Byte address of descriptor 0 |
| cfg_count | input | IDXW+1 | Number of descriptors in the ring |
| rx_valid | input | 1 | Packet byte valid |
| rx_ready | output | 1 | Engine accepts the byte |
| rx_data | input | 8 | Packet byte |
| rx_sop | input | 1 | First byte of a packet |
| rx_eop | input | 1 | Last byte of a packet |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Interrupt request |
| sts | output | 2 | bit 0 packet done, bit 1 overrun |
| sts_clr | input | 2 | Write-1-to-clear for sts |

## Verification
The bench walks the ring all the way round so that the wrap lands on a descriptor the engine has just returned to the host. A design that skipped the ownership test, or that failed to clear the bit on write-back, would overwrite the old packet instead of raising the overrun flag. The bench then checks that the dropped packet did not move the ring position, so a design that advanced on a drop would put the next packet in the wrong buffer. It sends packets of one byte, of exactly the buffer size, and longer than the buffer. It checks a marker byte just past each stored area, so an off-by-one in the size compare shows up as a corrupted marker or a wrong error bit. Finally it turns the engine off and on again in mid-ring, and checks that the next packet lands in descriptor 0.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   // control word layout, shared with software
   localparam int OWN_BIT  = 31;
   localparam int ERR_BIT  = 30;
   localparam int LEN_LSB  = 16;
   localparam int SIZE_LSB = 0;
   localparam int FIELD_MAX = 14;
   localparam int DESC_SHIFT = 3;   // 8 bytes per descriptor
   localparam int CTL_OFS    = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_CTL,
      ST_RD_ADR,
      ST_RECV,
      ST_WR_BYTE,
      ST_WB,
      ST_DROP
   } rxr_state_e;
endpackage

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
   parameter int IDXW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            adv,
   input  logic [IDXW:0]   count,
   output logic [IDXW-1:0] idx
);
   logic [IDXW:0] nxt;
   assign nxt = {1'b0, idx} + (IDXW+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx <= '0;
      else if (!en)      idx <= '0;
      else if (adv)      idx <= (nxt >= count) ? '0 : nxt[IDXW-1:0];
   end

   AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && (nxt >= count)) |=> (idx == '0)); // R7
   AST_IDX_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (idx == '0)); // R2
endmodule

// File: rtl/rxr_irq_status.sv
module rxr_irq_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_done,
   input  logic       set_ovr,
   input  logic [1:0] clr,
   output logic [1:0] sts,
   output logic       irq
);
   // a new event in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts <= '0;
      else begin
         sts[0] <= set_done | (sts[0] & ~clr[0]);
         sts[1] <= set_ovr  | (sts[1] & ~clr[1]);
      end
   end

   assign irq = |sts;

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[1] && !clr[1]) |=> sts[1]); // R8
   AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[0] && !set_done) |=> !sts[0]); // R9
endmodule

// File: rtl/rxr_dma_ring.sv
module rxr_dma_ring
   import rxr_pkg::*;
#(
   parameter int AW   = 32,
   parameter int IDXW = 8,
   parameter int LENW = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_en,
   input  logic [AW-1:0]   cfg_base,
   input  logic [IDXW:0]   cfg_count,
   input  logic            rx_valid,
   output logic            rx_ready,
   input  logic [7:0]      rx_data,
   input  logic            rx_sop,
   input  logic            rx_eop,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [3:0]      mem_be,
   output logic [31:0]     mem_wdata,
   input  logic            mem_ack,
   input  logic [31:0]     mem_rdata,
   output logic            irq,
   output logic [1:0]      sts,
   input  logic [1:0]      sts_clr
);
   localparam int LANES = 4;

   if (LENW < 1 || LENW > FIELD_MAX) begin : g_bad_lenw
      $error("rxr_dma_ring: LENW out of range");
   end
   if (AW < 16 || AW > 32) begin : g_bad_aw
      $error("rxr_dma_ring: AW out of range");
   end
   if (IDXW < 1 || IDXW > 16) begin : g_bad_idxw
      $error("rxr_dma_ring: IDXW out of range");
   end

   rxr_state_e      state;
   logic [LENW-1:0] ctl_size;
   logic [LENW-1:0] cnt;
   logic [AW-1:0]   buf_addr;
   logic [7:0]      byte_q;
   logic            last;
   logic            trunc;
   logic [IDXW-1:0] idx;
   logic [AW-1:0]   desc_addr;
   logic [AW-1:0]   wr_addr;
   logic [LANES-1:0] lane_be;
   logic [31:0]     wb_word;
   logic            done_evt;
   logic            ovr_evt;

   assign desc_addr = cfg_base + (AW'(idx) << DESC_SHIFT);
   assign wr_addr   = buf_addr + AW'(cnt);
   assign done_evt  = (state == ST_WB) && mem_ack;
   assign ovr_evt   = (state == ST_RD_CTL) && mem_ack && !mem_rdata[OWN_BIT];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_be[g] = (wr_addr[1:0] == 2'(g));
   end

   always_comb begin
      wb_word = '0;
      wb_word[ERR_BIT]            = trunc;
      wb_word[LEN_LSB +: LENW]    = cnt;
      wb_word[SIZE_LSB +: LENW]   = ctl_size;
   end

   rxr_ring_idx #(.IDXW(IDXW)) i_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg_en),
      .adv   (done_evt),
      .count (cfg_count),
      .idx   (idx)
   );

   rxr_irq_status i_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_done (done_evt),
      .set_ovr  (ovr_evt),
      .clr      (sts_clr),
      .sts      (sts),
      .irq      (irq)
   );

   always_comb begin
      case (state)
         ST_IDLE:         rx_ready = cfg_en && !rx_sop;
         ST_RECV, ST_DROP: rx_ready = 1'b1;
         default:         rx_ready = 1'b0;
      endcase
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = desc_addr + AW'(CTL_OFS);
      mem_be    = '1;
      mem_wdata = '0;
      case (state)
         ST_RD_CTL: mem_req = 1'b1;
         ST_RD_ADR: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr;
         end
         ST_WR_BYTE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = wr_addr;
            mem_be    = lane_be;
            mem_wdata = {LANES{byte_q}};
         end
         ST_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = wb_word;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ctl_size <= '0;
         cnt      <= '0;
         buf_addr <= '0;
         byte_q   <= '0;
         last     <= 1'b0;
         trunc    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE:
               if (cfg_en && rx_valid && rx_sop) state <= ST_RD_CTL;
            ST_RD_CTL:
               if (mem_ack) begin
                  if (mem_rdata[OWN_BIT]) begin
                     ctl_size <= mem_rdata[SIZE_LSB +: LENW];
                     state    <= ST_RD_ADR;
                  end else begin
                     state    <= ST_DROP;
                  end
               end
            ST_RD_ADR:
               if (mem_ack) begin
                  buf_addr <= mem_rdata[AW-1:0];
                  cnt      <= '0;
                  trunc    <= 1'b0;
                  state    <= ST_RECV;
               end
            ST_RECV:
               if (rx_valid) begin
                  byte_q <= rx_data;
                  last   <= rx_eop;
                  if (cnt < ctl_size) state <= ST_WR_BYTE;
                  else begin
                     trunc <= 1'b1;
                     if (rx_eop) state <= ST_WB;
                  end
               end
            ST_WR_BYTE:
               if (mem_ack) begin
                  cnt   <= cnt + 1'b1;
                  state <= last ? ST_WB : ST_RECV;
               end
            ST_WB:
               if (mem_ack) state <= ST_IDLE;
            ST_DROP:
               if (rx_valid && rx_eop) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_WRITE_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR_BYTE && mem_req) |-> (cnt < ctl_size)); // R6
   AST_WB_HANDS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WB && mem_req) |-> !mem_wdata[OWN_BIT]); // R5
   AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[0]) |-> $past(state == ST_WB && mem_ack)); // R9
   AST_DROP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DROP) |-> !mem_req); // R8
   AST_OFF_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && state == ST_IDLE) |-> (!mem_req && !rx_ready)); // R2
   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR_BYTE) |-> $onehot0(mem_be)); // R4
endmodule

// File: tb/test_rxr_dma_ring.sv
`timescale 1ns/100ps
module test_rxr_dma_ring;
   localparam int AW = 32;
   localparam int IDXW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_en = 1'b0;
   logic [AW-1:0]   cfg_base = 32'h100;
   logic [IDXW:0]   cfg_count = 9'd4;
   logic            rx_valid = 1'b0;
   logic            rx_ready;
   logic [7:0]      rx_data = '0;
   logic            rx_sop = 1'b0;
   logic            rx_eop = 1'b0;
   logic            mem_req, mem_we;
   logic [AW-1:0]   mem_addr;
   logic [3:0]      mem_be;
   logic [31:0]     mem_wdata, mem_rdata;
   logic            mem_ack;
   logic            irq;
   logic [1:0]      sts;
   logic            clr_done = 1'b0;
   logic            clr_ovr = 1'b0;

   logic [31:0] mem [0:255];
   logic        host_we = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [31:0] host_data = '0;

   int tests = 0;
   int fails = 0;

   typedef struct { int idx; int n; int size; int seed; } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk) begin
      if (host_we) mem[host_addr] <= host_data;
      if (mem_req && mem_we)
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
   end

   rxr_dma_ring #(.AW(AW), .IDXW(IDXW), .LENW(14)) i_rxr_dma_ring (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base),
      .cfg_count(cfg_count), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .irq(irq), .sts(sts),
      .sts_clr({clr_ovr, clr_done})
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rd_byte(input int a);
      return mem[(a >> 2) & 255][8*(a & 3) +: 8];
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", tests - fails, tests);
      $finish;
   endtask

   task automatic host_wr(input int w, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = 8'(w); host_data = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // hand descriptor idx to the device with a fresh marked buffer
   task automatic prepare(input int idx, input int size);
      host_wr(64 + 2*idx, 32'h200 + 32*idx);
      host_wr(65 + 2*idx, 32'h8000_0000 | size);
      for (int w = 0; w < 8; w++) host_wr(128 + 8*idx + w, 32'hEEEE_EEEE);
   endtask

   task automatic send_pkt(input int n, input int seed, input int idx, input int size, input bit drop);
      exp_t e;
      while (sts[0] || clr_done) @(negedge clk);
      if (!drop) begin
         e.idx = idx; e.n = n; e.size = size; e.seed = seed;
         sb_q.push_back(e);
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = 8'(seed + i);
         rx_sop = (i == 0); rx_eop = (i == n-1);
         #1;
         while (!rx_ready) begin @(negedge clk); #1; end
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
   endtask

   task automatic drain();
      while (sb_q.size() != 0 || sts[0] || clr_done) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: scoreboard compare on each completion
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n && sts[0]) begin
            if (sb_q.size() == 0) chk(1'b0, "R9 completion with nothing expected", 32'(sts), 32'd0);
            else begin
               int stored, ba;
               bit err, data_ok;
               logic [31:0] expw;
               e = sb_q.pop_front();
               stored = (e.n > e.size) ? e.size : e.n;
               err = (e.n > e.size);
               expw = (32'(err) << 30) | (32'(stored) << 16) | 32'(e.size);
               chk(mem[65 + 2*e.idx] == expw, "R5 R6 R7 control word write-back", mem[65 + 2*e.idx], expw);
               ba = 32'h200 + 32*e.idx;
               data_ok = 1'b1;
               for (int k = 0; k < stored; k++)
                  if (rd_byte(ba + k) !== 8'(e.seed + k)) data_ok = 1'b0;
               chk(data_ok, "R4 buffer bytes in order", 32'(rd_byte(ba)), 32'(8'(e.seed)));
               chk(rd_byte(ba + stored) == 8'hEE, "R6 byte past stored data untouched",
                   32'(rd_byte(ba + stored)), 32'hEE);
            end
            repeat (2) @(negedge clk);
            chk(sts[0] && irq, "R9 done status held until cleared", {30'd0, irq, sts[0]}, 32'd3);
            clr_done = 1'b1;
            @(negedge clk);
            clr_done = 1'b0;
            chk(!sts[0], "R9 done status cleared by write-1", 32'(sts[0]), 32'd0);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      bit quiet;
      repeat (3) @(negedge clk);
      chk(irq == 0 && sts == 0 && rx_ready == 0 && mem_req == 0, "R1 reset state",
          {28'd0, irq, sts, rx_ready}, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) prepare(i, 16);
      @(negedge clk);
      chk(rx_ready == 0 && mem_req == 0, "R1 R2 idle while disabled", {31'd0, rx_ready}, 32'd0);
      cfg_en = 1'b1;

      // R3 R4 R7: fill the ring with 5, 1, 16 and 20 (truncated) bytes
      send_pkt(5,  8'h10, 0, 16, 1'b0);
      send_pkt(1,  8'h30, 1, 16, 1'b0);
      send_pkt(16, 8'h40, 2, 16, 1'b0);
      send_pkt(20, 8'h60, 3, 16, 1'b0);
      drain();

      // R8: wrap lands on a host-owned descriptor
      send_pkt(6, 8'h90, 0, 16, 1'b1);
      repeat (3) @(negedge clk);
      chk(sts == 2'b10 && irq, "R8 overrun status set on drop", {29'd0, irq, sts}, 32'h6);
      chk(mem[65] == ((32'd5 << 16) | 32'd16), "R8 dropped packet left descriptor alone", mem[65],
          (32'd5 << 16) | 32'd16);
      chk(rd_byte(32'h200) == 8'h10, "R8 dropped packet wrote no buffer byte", 32'(rd_byte(32'h200)), 32'h10);
      repeat (4) @(negedge clk);
      chk(sts[1], "R8 overrun status sticky", 32'(sts[1]), 32'd1);
      clr_ovr = 1'b1;
      @(negedge clk);
      clr_ovr = 1'b0;
      chk(sts == 2'b00 && !irq, "R9 overrun cleared and irq low", {29'd0, irq, sts}, 32'd0);

      // R10: refill and reuse; the drop did not move the position (R8)
      prepare(0, 8);
      send_pkt(3, 8'hA0, 0, 8, 1'b0);
      prepare(1, 16);
      send_pkt(2, 8'hB0, 1, 16, 1'b0);
      drain();

      // R2: off with a packet waiting, then restart at descriptor 0
      @(negedge clk);
      cfg_en = 1'b0;
      rx_valid = 1'b1; rx_sop = 1'b1; rx_data = 8'h55;
      quiet = 1'b1;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         if (rx_ready || mem_req) quiet = 1'b0;
      end
      chk(quiet, "R2 no accept and no memory access while disabled", 32'(quiet), 32'd1);
      rx_valid = 1'b0; rx_sop = 1'b0;
      prepare(0, 4);
      @(negedge clk);
      cfg_en = 1'b1;
      send_pkt(6, 8'hC0, 0, 4, 1'b0);
      drain();
      chk(sb_q.size() == 0, "R7 every expected packet completed", 32'(sb_q.size()), 32'd0);
      finish_run();
   end
endmodule